// File: doc/BRIEF.md
# Triggered Single-Output PWM Timer

This block is a free-running 16-bit up-counter that draws a pulse-width waveform on one output pin. Two compare values act as edges. When the counter equals the set-compare value, the pin moves to its active level. When it equals the reset-compare value, the pin returns to its inactive level. A polarity bit swaps which level counts as active. A third compare value marks the end of a period, and a clear-enable bit decides whether the counter restarts from zero at that point.

A shadow register can hold the next reset-compare value. When buffering is on, the shadow is copied into the reset-compare register only at a period match or at a trigger event, so the duty cycle never changes partway through a period. The trigger is an asynchronous pin. It passes through a synchronizer and an edge detector. A two-bit edge-select field either ignores it or reacts to rising edges, falling edges or both. A trigger event clears the counter and, when buffering is on, performs the shadow copy.

Software programs the block through a small write-only port that has an address and a data word. The `run` input gates all counting and comparing.

Top module: `trig_pwm_timer`

## Requirements
- R1: While reset is asserted and right after it is released, `pwm_out` is 0. The counter, all compare values, the shadow and the control fields are 0.
- R2: While `run` is 1 and no clear applies, the counter advances by one on each clock and wraps from 0xFFFF to 0. While `run` is 0, the counter, the output and all compare actions are frozen.
- R3: With polarity 0, a counter match with the set-compare value makes `pwm_out` 1 on the next clock. A match with the reset-compare value makes it 0.
- R4: With polarity 1, the levels are swapped. A set-compare match gives 0 and a reset-compare match gives 1.
- R5: When the set-compare and reset-compare values both match in the same cycle, the reset-compare level is driven.
- R6: `pwm_out` changes only on a compare match. Writing the polarity bit or any compare value does not change the output by itself.
- R7: A period match resets the counter to 0 on the next clock only when clear-enable is 1. When clear-enable is 0, the counter keeps counting through the period value.
- R8: When buffer-enable is 1, a period match copies the shadow into the reset-compare register. When buffer-enable is 0, no copy takes place.
- R9: A write to the reset-compare address is used by compares from the next clock onward. If a shadow copy happens in the same cycle, the copy wins.
- R10: Edge select 00 ignores the trigger, 01 reacts to rising edges, 10 to falling edges and 11 to both. A level change on `trig_in` is seen at the third rising clock edge after it is first sampled. The resulting event, while `run` is 1, clears the counter and performs the shadow copy when buffer-enable is 1.
- R11: Write addresses are 0 period, 1 reset-compare, 2 set-compare, 3 shadow and 4 control. In the control word, bit 0 is polarity, bit 1 is buffer-enable, bit 2 is clear-enable and bits 4:3 are edge select. Addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| run | input | 1 | Timer enable; gates counting, compares and trigger actions |
| trig_in | input | 1 | Asynchronous external trigger |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
The assertions assume that `run` and the write port are synchronous to `clk`. They also assume that `trig_in` holds each level for at least one clock, so that the synchronizer never loses a pulse. This matters because the edge checks reason only about edges the synchronizer has captured. The stimulus drives every input on the falling clock edge. It holds each trigger level for dozens of cycles. It uses only addresses 0 to 4, and it programs compare and period values well inside the counting range. The one exception is the wrap run, which deliberately lets the counter pass 0xFFFF.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;

  typedef enum logic [2:0] {
    ADR_PERIOD = 3'd0,
    ADR_RSTCMP = 3'd1,
    ADR_SETCMP = 3'd2,
    ADR_SHADOW = 3'd3,
    ADR_CTRL   = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    ESEL_OFF  = 2'b00,
    ESEL_RISE = 2'b01,
    ESEL_FALL = 2'b10,
    ESEL_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] esel;
    logic       clr_en;
    logic       buf_en;
    logic       pol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tpt_regs.sv
module tpt_regs
  import trig_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              xfer,
  output logic [CNT_W-1:0]  per_q,
  output logic [CNT_W-1:0]  rcmp_q,
  output logic [CNT_W-1:0]  scmp_q,
  output ctrl_t             ctrl_q
);

  logic [CNT_W-1:0] per_d, rcmp_d, scmp_d, shadow_d, shadow_q;
  ctrl_t            ctrl_d;
  logic             sel_per, sel_rst, sel_set, sel_shd, sel_ctl;

  always_comb begin
    sel_per = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
    sel_rst = wr_en && (wr_addr == ADDR_W'(ADR_RSTCMP));
    sel_set = wr_en && (wr_addr == ADDR_W'(ADR_SETCMP));
    sel_shd = wr_en && (wr_addr == ADDR_W'(ADR_SHADOW));
    sel_ctl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  end

  always_comb begin
    per_d    = sel_per ? wr_data : per_q;
    scmp_d   = sel_set ? wr_data : scmp_q;
    shadow_d = sel_shd ? wr_data : shadow_q;
    ctrl_d   = sel_ctl ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    // shadow copy beats a direct write in the same cycle
    if (xfer)         rcmp_d = shadow_q;
    else if (sel_rst) rcmp_d = wr_data;
    else              rcmp_d = rcmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      rcmp_q   <= '0;
      scmp_q   <= '0;
      shadow_q <= '0;
      ctrl_q   <= '0;
    end else begin
      per_q    <= per_d;
      rcmp_q   <= rcmp_d;
      scmp_q   <= scmp_d;
      shadow_q <= shadow_d;
      ctrl_q   <= ctrl_d;
    end
  end

endmodule

// File: rtl/tpt_trig.sv
module tpt_trig
  import trig_pwm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] esel,
  output logic       trig_evt
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q;
  logic                   lvl, rise, fall;

  always_comb begin
    for (int i = 0; i < SYNC_STAGES; i++) begin
      sync_d[i] = (i == 0) ? trig_in : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    lvl  = sync_q[SYNC_STAGES-1];
    rise = lvl & ~last_q;
    fall = ~lvl & last_q;
    unique case (edge_sel_e'(esel))
      ESEL_RISE: trig_evt = rise;
      ESEL_FALL: trig_evt = fall;
      ESEL_BOTH: trig_evt = rise | fall;
      default:   trig_evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/tpt_counter.sv
module tpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (clear) cnt_d = '0;
      else       cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer
  import trig_pwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              run,
  input  logic              trig_in,
  output logic              pwm_out
);

  localparam int N_CMP = 3;
  localparam int K_PER = 0;
  localparam int K_SET = 1;
  localparam int K_RST = 2;

  logic [CNT_W-1:0] per_q, rcmp_q, scmp_q, cnt_q;
  ctrl_t            ctrl_q;
  logic             trig_evt, trig_fire, clear, xfer;
  logic             per_hit, set_hit, rst_hit;
  logic             pwm_d, pwm_q;
  logic [CNT_W-1:0] cmp_val [N_CMP];
  logic [N_CMP-1:0] hit;

  tpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .xfer   (xfer),
    .per_q  (per_q),
    .rcmp_q (rcmp_q),
    .scmp_q (scmp_q),
    .ctrl_q (ctrl_q)
  );

  tpt_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .esel    (ctrl_q.esel),
    .trig_evt(trig_evt)
  );

  tpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .clear(clear),
    .cnt_q(cnt_q)
  );

  assign cmp_val[K_PER] = per_q;
  assign cmp_val[K_SET] = scmp_q;
  assign cmp_val[K_RST] = rcmp_q;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign hit[k] = run & (cnt_q == cmp_val[k]);
  end

  always_comb begin
    per_hit   = hit[K_PER];
    set_hit   = hit[K_SET];
    rst_hit   = hit[K_RST];
    trig_fire = run & trig_evt;
    clear     = trig_fire | (per_hit & ctrl_q.clr_en);
    xfer      = ctrl_q.buf_en & (trig_fire | per_hit);
    // reset-compare has priority; its level equals the polarity bit
    if (rst_hit)      pwm_d = ctrl_q.pol;
    else if (set_hit) pwm_d = ~ctrl_q.pol;
    else              pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_out = pwm_q;

endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             clear,
  input logic             per_hit,
  input logic             clr_en,
  input logic             set_hit,
  input logic             rst_hit,
  input logic             pol,
  input logic             pwm_out,
  input logic [1:0]       esel,
  input logic             trig_fire
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(pwm_out)));

  a_r7_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && clr_en) |=> (cnt == '0));

  a_r5_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (pwm_out == $past(pol)));

  a_r3_set_level: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !rst_hit) |=> (pwm_out == !$past(pol)));

  a_r6_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit && !rst_hit) |=> $stable(pwm_out));

  a_r10_trig_off: assert property (@(posedge clk) disable iff (!rst_n)
    (esel == 2'b00) |-> !trig_fire);

  a_r10_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (cnt == '0));

endmodule

bind trig_pwm_timer tpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .cnt      (cnt_q),
  .clear    (clear),
  .per_hit  (per_hit),
  .clr_en   (ctrl_q.clr_en),
  .set_hit  (set_hit),
  .rst_hit  (rst_hit),
  .pol      (ctrl_q.pol),
  .pwm_out  (pwm_out),
  .esel     (ctrl_q.esel),
  .trig_fire(trig_fire)
);

// File: tb/trig_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module trig_pwm_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        run;
  logic        trig_in;
  logic        pwm_out;

  int    n_cmp;
  int    n_bad;
  bit    done;
  string cur_req;

  // behavioural reference state
  int m_cnt, m_per, m_rc, m_sc, m_shd, m_ctl, m_pwm;
  bit hist[$];

  trig_pwm_timer dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .run    (run),
    .trig_in(trig_in),
    .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_rc = 0; m_sc = 0; m_shd = 0; m_ctl = 0; m_pwm = 0;
      hist.delete();
    end else begin
      int  sz;
      bit  a, b, ev, pm, sh, rh, pol, ben, clr;
      int  esel;
      sz   = hist.size();
      a    = (sz >= 2) ? hist[sz-2] : 1'b0;
      b    = (sz >= 3) ? hist[sz-3] : 1'b0;
      pol  = m_ctl[0];
      ben  = m_ctl[1];
      clr  = m_ctl[2];
      esel = (m_ctl >> 3) & 3;
      ev   = run && (((esel & 1) != 0 && a && !b) || ((esel & 2) != 0 && !a && b));
      pm   = run && (m_cnt == m_per);
      sh   = run && (m_cnt == m_sc);
      rh   = run && (m_cnt == m_rc);
      if (rh)      m_pwm = pol;
      else if (sh) m_pwm = !pol;
      if (run) m_cnt = (ev || (pm && clr)) ? 0 : ((m_cnt + 1) & 16'hFFFF);
      if (ben && (pm || ev))            m_rc = m_shd;
      else if (wr_en && wr_addr == 3'd1) m_rc = wr_data;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per = wr_data;
          3'd2: m_sc  = wr_data;
          3'd3: m_shd = wr_data;
          3'd4: m_ctl = wr_data & 16'h1F;
          default: ;
        endcase
      end
      hist.push_back(trig_in);
      if (hist.size() > 6) void'(hist.pop_front());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (pwm_out !== m_pwm[0]) begin
        n_bad++;
        $display("FAIL %s t=%0t pwm_out actual=%b expected=%0d", cur_req, $time, pwm_out, m_pwm);
      end
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr[2:0];
    wr_data = data[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    cur_req = "R1";
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; run = 1'b0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (pwm_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 pwm_out in reset actual=%b expected=0", pwm_out);
    end
    rst_n = 1'b1;
    idle(4);

    cur_req = "R11";               // programming through the address map
    wr(0, 16'h0040);
    wr(2, 16'h0010);
    wr(1, 16'h0030);
    wr(5, 16'h0001);               // unmapped address, ignored
    wr(4, 16'h0004);               // clear-enable
    cur_req = "R3";
    run = 1'b1;
    idle(200);

    cur_req = "R2";                // run low freezes everything
    run = 1'b0;
    idle(25);
    run = 1'b1;
    idle(90);

    cur_req = "R6";                // polarity flip alone must not move the pin
    wr(4, 16'h0005);
    idle(3);
    cur_req = "R4";
    idle(200);

    cur_req = "R5";                // coincident set and reset matches
    wr(1, 16'h0020);
    wr(2, 16'h0020);
    idle(150);
    wr(4, 16'h0004);
    idle(150);

    cur_req = "R9";                // direct reset-compare writes
    wr(2, 16'h0008);
    for (int i = 0; i < 4; i++) begin
      wr(1, 16'h0018 + 16'(i * 9));
      idle(37 + i * 11);
    end

    cur_req = "R8";                // buffered reload at period match
    wr(3, 16'h0038);
    wr(4, 16'h0006);
    for (int i = 0; i < 4; i++) begin
      wr(3, 16'h000C + 16'(i * 13));
      wr(1, 16'h003E);             // may collide with a shadow copy
      idle(55 + i * 7);
    end

    cur_req = "R7";                // no clear: count through period and wrap
    wr(4, 16'h0002);
    wr(3, 16'h0030);
    cur_req = "R2";
    idle(70000);

    cur_req = "R10";               // trigger edge selects
    wr(0, 16'h0200);
    wr(2, 16'h0020);
    wr(1, 16'h0100);
    for (int e = 0; e < 4; e++) begin
      wr(4, (e << 3) | 16'h0006);
      for (int p = 0; p < 3; p++) begin
        wr(3, 16'h0040 + 16'(e * 32 + p * 8));
        trig_in = 1'b1;
        idle(37 + p * 5);
        trig_in = 1'b0;
        idle(53 + e * 3);
      end
    end
    wr(4, 16'h001D);               // both edges, no buffer, polarity 1
    for (int p = 0; p < 3; p++) begin
      trig_in = ~trig_in;
      idle(41 + p * 17);
    end
    idle(20);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule